// File: doc/BRIEF.md
# Paired-Word SEC-DED Memory Controller

This block stores a 64-bit word with single-error-correct, double-error-detect protection in memory that has only 36 bits per location: 32 data bits and 4 byte-parity lanes. The eight check bits of a Hsiao-style code are split into two groups of four. One group rides in the parity lanes of the low-half access and the other in the lanes of the high-half access. A write therefore becomes two back-to-back 36-bit memory writes. A read becomes two 36-bit reads, followed by a syndrome evaluation over the combined 72-bit codeword. The check bits are produced by two 32-bit slices. Each slice owns half of the code columns, and their partial results are XORed into one shared check vector.

Protection can be switched off. The block also drops to plain byte parity when the bank count is odd, because correction needs banks that are populated in pairs. In parity mode each lane holds the even parity of its data byte. On a read, a byte mismatch is then only detected and reported, and the data is returned unmodified. Every read returns a one-cycle result pulse with the data, a corrected-error flag, an uncorrectable-error flag and a held syndrome value for logging.

The host presents a request only while `busy` is low. A write request wins over a read request in the same cycle. The memory answers each read access with `mem_rvalid` and `mem_rdata` one or more cycles later, in issue order.

Top module: `pwecc_ctrl`

## Requirements
- R1: A write accepted in cycle t produces memory writes in cycles t+1 and t+2. The first goes to address {addr,0} and carries data bits 31:0. The second goes to {addr,1} and carries data bits 63:32. In both, bits 31:0 of `mem_wdata` hold data and bits 35:32 hold the lanes.
- R2: With protection active, the lanes of the low access hold check bits 3:0 and the lanes of the high access hold check bits 7:4. Check bit k is the XOR of every data bit j whose column has bit k set. Columns 0..55 are the 8-bit values of weight 3 in ascending order, and columns 56..63 are the first eight weight-5 values in ascending order. Check bit k alone has the column 1<<k.
- R3: A read accepted in cycle t issues read accesses to {addr,0} and {addr,1} in cycles t+1 and t+2. `rd_valid` is a one-cycle pulse, raised in the second cycle after the cycle in which the high half's `mem_rvalid` is presented. With a one-cycle memory this is cycle t+5.
- R4: Reading a clean location returns the written word. Both error flags stay low and the syndrome is 0.
- R5: A single flipped bit anywhere in the 72-bit codeword is corrected. The data matches the written word, `err_corr` pulses with `rd_valid`, and the syndrome equals that bit's column.
- R6: Two flipped bits raise `err_uncorr` and never `err_corr`. The raw data is returned without modification, and the syndrome equals the XOR of the two columns.
- R7: With protection off, lane i of each access holds the XOR of byte i of that 32-bit half. This is even parity, with bit 32+i covering data bits 8i+7..8i.
- R8: In parity mode a read returns the raw data. Syndrome bit b is set when byte b of the 64-bit word fails parity, with bytes 0..3 from the low access. `err_uncorr` pulses when any bit is set, and `err_corr` never pulses.
- R9: An odd `cfg_bank_cnt` forces parity mode even with `cfg_ecc_en` high.
- R10: After reset, `busy`, `mem_req`, `rd_valid` and both error flags are low and the syndrome is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_ecc_en | input | 1 | Request SEC-DED protection |
| cfg_bank_cnt | input | BANK_W | Populated bank count; odd forces parity mode |
| wr_req | input | 1 | Write request (takes priority) |
| rd_req | input | 1 | Read request |
| req_addr | input | ADDR_W | Word address of the request |
| wr_data | input | DATA_W | Word to write |
| busy | output | 1 | Operation in progress; requests not taken |
| rd_valid | output | 1 | One-cycle read result pulse |
| rd_data | output | DATA_W | Read word (corrected when possible) |
| err_corr | output | 1 | Single error corrected, with rd_valid |
| err_uncorr | output | 1 | Uncorrectable or parity error, with rd_valid |
| syndrome | output | 8 | Held syndrome or byte-mismatch mask of last read |
| mem_req | output | 1 | Memory access strobe |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | ADDR_W+1 | {word address, half select} |
| mem_wdata | output | DATA_W/2+DATA_W/16 | Lanes and data half for a write |
| mem_rvalid | input | 1 | Read data present |
| mem_rdata | input | DATA_W/2+DATA_W/16 | Lanes and data half returned |

## Verification
The bench builds the controller with `ADDR_W` = 4 and `BANK_W` = 3. The 4-bit address keeps its own memory model at 32 locations of 36 bits, so it can flip any of the 72 codeword bits at chosen addresses between the write and the read. The 3-bit bank count reaches both even and odd values. The odd values let the same stimulus run with protection requested but overridden to parity. The 64-bit data width is the only one the code table supports, so all column positions, including the eight weight-5 columns and the eight check-bit positions, are exercised by single-bit and double-bit injections.

// File: rtl/pwecc_pkg.sv
package pwecc_pkg;

   localparam int CODE_CHK_W = 8;
   localparam int CODE_MAX_W = 64;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_W_LO,
      ST_W_HI,
      ST_R_LO,
      ST_R_HI,
      ST_R_WAIT,
      ST_R_DEC
   } ctl_state_e;

   // Column of data bit j: weight-3 values ascending, then weight-5 values ascending.
   function automatic logic [CODE_CHK_W-1:0] col_of(input int j);
      int seen;
      logic [CODE_CHK_W-1:0] res;
      res  = '0;
      seen = 0;
      for (int v = 1; v < 256; v++) begin
         if ($countones(v[7:0]) == 3) begin
            if (seen == j) res = v[7:0];
            seen++;
         end
      end
      for (int v = 1; v < 256; v++) begin
         if ($countones(v[7:0]) == 5) begin
            if (seen == j) res = v[7:0];
            seen++;
         end
      end
      return res;
   endfunction

   // Which of `width` data bits starting at column `base` feed check bit k.
   function automatic logic [CODE_MAX_W-1:0] row_mask(input int base, input int width, input int k);
      logic [CODE_MAX_W-1:0] m;
      logic [CODE_CHK_W-1:0] c;
      m = '0;
      for (int i = 0; i < width; i++) begin
         c    = col_of(base + i);
         m[i] = c[k];
      end
      return m;
   endfunction

endpackage

// File: rtl/pwecc_slice.sv
module pwecc_slice #(
   parameter int BASE  = 0,
   parameter int WIDTH = 32,
   parameter int CHK_W = 8
) (
   input  logic [WIDTH-1:0] d,
   output logic [CHK_W-1:0] part
);

   if (WIDTH > pwecc_pkg::CODE_MAX_W) begin : g_bad_width
      $error("pwecc_slice: WIDTH exceeds code table");
   end
   if (CHK_W != pwecc_pkg::CODE_CHK_W) begin : g_bad_chk
      $error("pwecc_slice: CHK_W must be 8");
   end

   for (genvar k = 0; k < CHK_W; k++) begin : g_row
      localparam logic [pwecc_pkg::CODE_MAX_W-1:0] MASK = pwecc_pkg::row_mask(BASE, WIDTH, k);
      assign part[k] = ^(d & MASK[WIDTH-1:0]);
   end

endmodule

// File: rtl/pwecc_decode.sv
module pwecc_decode #(
   parameter int DATA_W = 64,
   parameter int CHK_W  = 8
) (
   input  logic [CHK_W-1:0]  syn,
   input  logic [DATA_W-1:0] raw,
   output logic [DATA_W-1:0] flip,
   output logic [DATA_W-1:0] fixed,
   output logic              single,
   output logic              uncorr
);

   logic chk_hit;

   for (genvar j = 0; j < DATA_W; j++) begin : g_col
      localparam logic [CHK_W-1:0] COL = pwecc_pkg::col_of(j);
      assign flip[j] = (syn == COL);
   end

   always_comb begin
      chk_hit = (syn != '0) && ((syn & (syn - 1'b1)) == '0);
      single  = (|flip) || chk_hit;
      uncorr  = (syn != '0) && !single;
      fixed   = raw ^ flip;
   end

endmodule

// File: rtl/pwecc_ctrl.sv
module pwecc_ctrl #(
   parameter int DATA_W = 64,
   parameter int ADDR_W = 20,
   parameter int BANK_W = 3
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          cfg_ecc_en,
   input  logic [BANK_W-1:0]             cfg_bank_cnt,
   input  logic                          wr_req,
   input  logic                          rd_req,
   input  logic [ADDR_W-1:0]             req_addr,
   input  logic [DATA_W-1:0]             wr_data,
   output logic                          busy,
   output logic                          rd_valid,
   output logic [DATA_W-1:0]             rd_data,
   output logic                          err_corr,
   output logic                          err_uncorr,
   output logic [7:0]                    syndrome,
   output logic                          mem_req,
   output logic                          mem_we,
   output logic [ADDR_W:0]               mem_addr,
   output logic [DATA_W/2+DATA_W/16-1:0] mem_wdata,
   input  logic                          mem_rvalid,
   input  logic [DATA_W/2+DATA_W/16-1:0] mem_rdata
);
   import pwecc_pkg::*;

   localparam int HALF_W  = DATA_W / 2;
   localparam int LANE_W  = HALF_W / 8;
   localparam int CHK_W   = CODE_CHK_W;
   localparam int NBYTE   = DATA_W / 8;
   localparam int MEM_W   = HALF_W + LANE_W;

   if (DATA_W != CODE_MAX_W) begin : g_bad_data
      $error("pwecc_ctrl: DATA_W must be 64");
   end
   if (2 * LANE_W != CHK_W) begin : g_bad_lane
      $error("pwecc_ctrl: lanes per pair must equal check bits");
   end
   if (BANK_W < 1) begin : g_bad_bank
      $error("pwecc_ctrl: BANK_W must be at least 1");
   end

   ctl_state_e          st;
   logic [ADDR_W-1:0]   addr_q;
   logic [DATA_W-1:0]   dbuf;
   logic [CHK_W-1:0]    cbuf;
   logic                ecc_q;
   logic                got_lo;

   logic                ecc_req;
   logic                take_wr;
   logic                take_rd;
   logic [CHK_W-1:0]    part [2];
   logic [CHK_W-1:0]    chk_calc;
   logic [NBYTE-1:0]    par_bits;
   logic [CHK_W-1:0]    syn;
   logic [NBYTE-1:0]    pmask;
   logic [LANE_W-1:0]   lane_lo;
   logic [LANE_W-1:0]   lane_hi;
   logic [DATA_W-1:0]   dec_flip;
   logic [DATA_W-1:0]   dec_fixed;
   logic                dec_single;
   logic                dec_uncorr;

   // Protection only when requested and banks come in pairs
   assign ecc_req = cfg_ecc_en && !cfg_bank_cnt[0];
   assign take_wr = (st == ST_IDLE) && wr_req;
   assign take_rd = (st == ST_IDLE) && rd_req && !wr_req;
   assign busy    = (st != ST_IDLE);

   // Two chained check slices, one per half
   for (genvar h = 0; h < 2; h++) begin : g_slice
      pwecc_slice #(
         .BASE (h * HALF_W),
         .WIDTH(HALF_W),
         .CHK_W(CHK_W)
      ) u_slice (
         .d   (dbuf[h*HALF_W +: HALF_W]),
         .part(part[h])
      );
   end
   assign chk_calc = part[0] ^ part[1];

   for (genvar b = 0; b < NBYTE; b++) begin : g_par
      assign par_bits[b] = ^dbuf[8*b +: 8];
   end

   assign syn   = chk_calc ^ cbuf;
   assign pmask = par_bits ^ cbuf;

   pwecc_decode #(
      .DATA_W(DATA_W),
      .CHK_W (CHK_W)
   ) u_dec (
      .syn   (syn),
      .raw   (dbuf),
      .flip  (dec_flip),
      .fixed (dec_fixed),
      .single(dec_single),
      .uncorr(dec_uncorr)
   );

   always_comb begin
      lane_lo   = ecc_q ? chk_calc[LANE_W-1:0]      : par_bits[LANE_W-1:0];
      lane_hi   = ecc_q ? chk_calc[CHK_W-1:LANE_W]  : par_bits[NBYTE-1:LANE_W];
      mem_req   = (st == ST_W_LO) || (st == ST_W_HI) || (st == ST_R_LO) || (st == ST_R_HI);
      mem_we    = (st == ST_W_LO) || (st == ST_W_HI);
      mem_addr  = {addr_q, (st == ST_W_HI) || (st == ST_R_HI)};
      mem_wdata = (st == ST_W_HI) ? {lane_hi, dbuf[DATA_W-1:HALF_W]}
                                  : {lane_lo, dbuf[HALF_W-1:0]};
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st         <= ST_IDLE;
         addr_q     <= '0;
         dbuf       <= '0;
         cbuf       <= '0;
         ecc_q      <= 1'b0;
         got_lo     <= 1'b0;
         rd_valid   <= 1'b0;
         rd_data    <= '0;
         err_corr   <= 1'b0;
         err_uncorr <= 1'b0;
         syndrome   <= '0;
      end else begin
         rd_valid   <= 1'b0;
         err_corr   <= 1'b0;
         err_uncorr <= 1'b0;
         case (st)
            ST_IDLE: begin
               if (take_wr) begin
                  addr_q <= req_addr;
                  dbuf   <= wr_data;
                  ecc_q  <= ecc_req;
                  st     <= ST_W_LO;
               end else if (take_rd) begin
                  addr_q <= req_addr;
                  ecc_q  <= ecc_req;
                  got_lo <= 1'b0;
                  st     <= ST_R_LO;
               end
            end
            ST_W_LO: st <= ST_W_HI;
            ST_W_HI: st <= ST_IDLE;
            ST_R_LO: st <= ST_R_HI;
            ST_R_HI, ST_R_WAIT: begin
               if (st == ST_R_HI) st <= ST_R_WAIT;
               if (mem_rvalid) begin
                  if (!got_lo) begin
                     dbuf[HALF_W-1:0]    <= mem_rdata[HALF_W-1:0];
                     cbuf[LANE_W-1:0]    <= mem_rdata[MEM_W-1:HALF_W];
                     got_lo              <= 1'b1;
                  end else begin
                     dbuf[DATA_W-1:HALF_W] <= mem_rdata[HALF_W-1:0];
                     cbuf[CHK_W-1:LANE_W]  <= mem_rdata[MEM_W-1:HALF_W];
                     st                    <= ST_R_DEC;
                  end
               end
            end
            ST_R_DEC: begin
               rd_valid   <= 1'b1;
               rd_data    <= ecc_q ? dec_fixed : dbuf;
               err_corr   <= ecc_q && dec_single;
               err_uncorr <= ecc_q ? dec_uncorr : (|pmask);
               syndrome   <= ecc_q ? syn : pmask;
               st         <= ST_IDLE;
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   // ---------------- assertions ----------------
   p_wr_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_req && !busy) |=> (mem_req && mem_we && !mem_addr[0]))
      else $error("write did not start with low half");

   p_wr_pair_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we && !mem_addr[0]) |=>
      (mem_req && mem_we && mem_addr[0] && (mem_addr[ADDR_W:1] == $past(mem_addr[ADDR_W:1]))))
      else $error("high-half write did not follow low half");

   p_rd_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && !wr_req && !busy) |=> (mem_req && !mem_we && !mem_addr[0]))
      else $error("read did not start with low half");

   p_rdv_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |=> !rd_valid)
      else $error("rd_valid longer than one cycle");

   p_flag_with_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (err_corr || err_uncorr) |-> rd_valid)
      else $error("error flag without read result");

   p_flags_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(err_corr && err_uncorr))
      else $error("both error flags raised");

   p_flip_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_R_DEC) |-> $onehot0(dec_flip))
      else $error("more than one column matched");

   p_dbl_passthru_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_R_DEC && ecc_q && syn != '0 && (^syn) == 1'b0) |=>
      (rd_data == $past(dbuf) && err_uncorr && !err_corr))
      else $error("double error not passed through");

   p_par_nocorr_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_R_DEC && !ecc_q) |=> !err_corr)
      else $error("correction reported in parity mode");

endmodule

// File: tb/sim_pwecc_ctrl.sv
module sim_pwecc_ctrl;
   localparam int CLK_PERIOD = 10;
   localparam int ADDR_W = 4;
   localparam int BANK_W = 3;
   localparam int MW     = 36;

   logic              clk = 1'b0;
   logic              rst_n;
   logic              cfg_ecc_en;
   logic [BANK_W-1:0] cfg_bank_cnt;
   logic              wr_req, rd_req;
   logic [ADDR_W-1:0] req_addr;
   logic [63:0]       wr_data;
   logic              busy, rd_valid, err_corr, err_uncorr;
   logic [63:0]       rd_data;
   logic [7:0]        syndrome;
   logic              mem_req, mem_we;
   logic [ADDR_W:0]   mem_addr;
   logic [MW-1:0]     mem_wdata;
   logic              mem_rvalid;
   logic [MW-1:0]     mem_rdata;

   logic [MW-1:0] mem [0:(1<<(ADDR_W+1))-1];

   int n_chk = 0;
   int n_bad = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pwecc_ctrl #(.DATA_W(64), .ADDR_W(ADDR_W), .BANK_W(BANK_W)) u0 (
      .clk(clk), .rst_n(rst_n), .cfg_ecc_en(cfg_ecc_en), .cfg_bank_cnt(cfg_bank_cnt),
      .wr_req(wr_req), .rd_req(rd_req), .req_addr(req_addr), .wr_data(wr_data),
      .busy(busy), .rd_valid(rd_valid), .rd_data(rd_data), .err_corr(err_corr),
      .err_uncorr(err_uncorr), .syndrome(syndrome), .mem_req(mem_req), .mem_we(mem_we),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata));

   // one-cycle synchronous memory model
   always @(posedge clk) begin
      if (!rst_n) begin
         mem_rvalid <= 1'b0;
         mem_rdata  <= '0;
      end else begin
         if (mem_req && mem_we) mem[mem_addr] <= mem_wdata;
         mem_rvalid <= mem_req && !mem_we;
         mem_rdata  <= mem[mem_addr];
      end
   end

   // ---------- reference model from the requirements ----------
   function automatic logic [7:0] ref_col(input int p);
      int cnt;
      logic [7:0] r;
      if (p >= 64) return 8'd1 << (p - 64);
      cnt = 0;
      r = 8'h00;
      for (int w = 3; w <= 5; w += 2)
         for (int v = 0; v < 256; v++)
            if ($countones(v[7:0]) == w) begin
               if (cnt == p) r = v[7:0];
               cnt++;
            end
      return r;
   endfunction

   function automatic logic [7:0] ref_chk(input logic [63:0] d);
      logic [7:0] c = 8'h00;
      for (int j = 0; j < 64; j++)
         if (d[j]) c ^= ref_col(j);
      return c;
   endfunction

   function automatic logic [7:0] ref_par(input logic [63:0] d);
      logic [7:0] q;
      for (int b = 0; b < 8; b++) q[b] = ^d[8*b +: 8];
      return q;
   endfunction

   task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // flip codeword bit p (0..63 data, 64..71 check) at word address a
   task automatic inject(input logic [ADDR_W-1:0] a, input int p);
      if (p < 32)       mem[{a,1'b0}][p]         = ~mem[{a,1'b0}][p];
      else if (p < 64)  mem[{a,1'b1}][p-32]      = ~mem[{a,1'b1}][p-32];
      else if (p < 68)  mem[{a,1'b0}][32+p-64]   = ~mem[{a,1'b0}][32+p-64];
      else              mem[{a,1'b1}][32+p-68]   = ~mem[{a,1'b1}][32+p-68];
   endtask

   task automatic do_write(input logic [ADDR_W-1:0] a, input logic [63:0] d, input bit ecc_mode);
      logic [7:0] lanes;
      lanes = ecc_mode ? ref_chk(d) : ref_par(d);
      @(negedge clk);
      wr_req = 1'b1; req_addr = a; wr_data = d;
      @(negedge clk);
      wr_req = 1'b0;
      // R1 / R2 / R7: low access in cycle t+1
      check(mem_req && mem_we && mem_addr == {a,1'b0}, "R1 low write strobe/addr",
            {mem_req, mem_we, mem_addr}, {2'b11, a, 1'b0});
      check(mem_wdata == {lanes[3:0], d[31:0]}, ecc_mode ? "R2 low lanes+data" : "R7 low parity lanes",
            mem_wdata, {lanes[3:0], d[31:0]});
      @(negedge clk);
      check(mem_req && mem_we && mem_addr == {a,1'b1}, "R1 high write strobe/addr",
            {mem_req, mem_we, mem_addr}, {2'b11, a, 1'b1});
      check(mem_wdata == {lanes[7:4], d[63:32]}, ecc_mode ? "R2 high lanes+data" : "R7 high parity lanes",
            mem_wdata, {lanes[7:4], d[63:32]});
      @(negedge clk);
   endtask

   logic [63:0] g_data;
   logic [7:0]  g_syn;
   logic        g_corr, g_unc;
   int          g_lat;

   task automatic do_read(input logic [ADDR_W-1:0] a);
      @(negedge clk);
      rd_req = 1'b1; req_addr = a;
      @(negedge clk);
      rd_req = 1'b0;
      g_lat = 1;
      while (!rd_valid && g_lat < 20) begin
         @(negedge clk);
         g_lat++;
      end
      g_data = rd_data; g_syn = syndrome; g_corr = err_corr; g_unc = err_uncorr;
   endtask

   // watchdog
   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      int seed_init;
      logic [63:0] d;
      logic [ADDR_W-1:0] a;
      seed_init = $urandom(32'h5EC0DE);
      rst_n = 1'b0; cfg_ecc_en = 1'b1; cfg_bank_cnt = 3'd2;
      wr_req = 1'b0; rd_req = 1'b0; req_addr = '0; wr_data = '0;
      for (int i = 0; i < (1 << (ADDR_W+1)); i++) mem[i] = '0;
      repeat (3) @(negedge clk);
      // R10 reset state
      check(!busy && !mem_req && !rd_valid && !err_corr && !err_uncorr, "R10 reset controls",
            {busy, mem_req, rd_valid, err_corr, err_uncorr}, 0);
      check(syndrome == 8'h00, "R10 reset syndrome", syndrome, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // Directed clean words plus latency (R3, R4)
      do_write(4'd0, 64'h0, 1'b1);
      do_read(4'd0);
      check(g_lat == 5, "R3 read latency", g_lat, 5);
      check(g_data == 64'h0 && !g_corr && !g_unc && g_syn == 0, "R4 zero word", g_data, 0);
      @(negedge clk);
      check(!rd_valid, "R3 rd_valid single pulse", rd_valid, 0);
      do_write(4'd15, '1, 1'b1);
      do_read(4'd15);
      check(g_data == '1 && !g_corr && !g_unc && g_syn == 0, "R4 ones word", g_data, '1);

      // Random clean traffic (R1 R2 R4)
      for (int i = 0; i < 40; i++) begin
         d = {$urandom, $urandom};
         a = ADDR_W'($urandom);
         do_write(a, d, 1'b1);
         do_read(a);
         check(g_data == d && !g_corr && !g_unc && g_syn == 0, "R4 random clean", g_data, d);
      end

      // Every single-bit position (R5)
      for (int p = 0; p < 72; p++) begin
         d = {$urandom, $urandom};
         a = ADDR_W'(p);
         do_write(a, d, 1'b1);
         inject(a, p);
         do_read(a);
         check(g_data == d, "R5 corrected data", g_data, d);
         check(g_corr && !g_unc, "R5 corrected flag", {g_corr, g_unc}, 2'b10);
         check(g_syn == ref_col(p), "R5 syndrome column", g_syn, ref_col(p));
      end

      // Double-bit errors (R6)
      for (int i = 0; i < 40; i++) begin
         int p, q;
         logic [63:0] raw;
         p = int'($urandom % 72);
         q = (p + 1 + int'($urandom % 71)) % 72;
         d = {$urandom, $urandom};
         a = ADDR_W'($urandom);
         do_write(a, d, 1'b1);
         inject(a, p); inject(a, q);
         raw = d;
         if (p < 64) raw[p] = ~raw[p];
         if (q < 64) raw[q] = ~raw[q];
         do_read(a);
         check(g_data == raw, "R6 raw passthrough", g_data, raw);
         check(g_unc && !g_corr, "R6 uncorrectable flag", {g_corr, g_unc}, 2'b01);
         check(g_syn == (ref_col(p) ^ ref_col(q)), "R6 syndrome", g_syn, ref_col(p) ^ ref_col(q));
      end

      // Parity mode via enable off (R7, R8)
      cfg_ecc_en = 1'b0;
      for (int i = 0; i < 20; i++) begin
         int p;
         logic [63:0] raw;
         d = {$urandom, $urandom};
         a = ADDR_W'($urandom);
         do_write(a, d, 1'b0);
         do_read(a);
         check(g_data == d && !g_unc && !g_corr && g_syn == 0, "R8 parity clean", g_data, d);
         p = int'($urandom % 64);
         inject(a, p);
         raw = d; raw[p] = ~raw[p];
         do_read(a);
         check(g_data == raw, "R8 parity raw data", g_data, raw);
         check(g_unc && !g_corr, "R8 parity flags", {g_corr, g_unc}, 2'b01);
         check(g_syn == (8'd1 << (p/8)), "R8 byte mask", g_syn, 8'd1 << (p/8));
      end

      // Odd bank count overrides enable (R9)
      cfg_ecc_en = 1'b1; cfg_bank_cnt = 3'd3;
      for (int i = 0; i < 10; i++) begin
         int p;
         d = {$urandom, $urandom};
         a = ADDR_W'($urandom);
         do_write(a, d, 1'b0);
         p = int'($urandom % 64);
         inject(a, p);
         do_read(a);
         check(g_unc && !g_corr && g_syn == (8'd1 << (p/8)), "R9 odd banks parity only",
               {g_corr, g_unc, g_syn}, {2'b01, 8'd1 << (p/8)});
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule